// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a 12-bit voltage-output converter. A host sends 16-bit words over three wires: a serial clock, a serial data line and an active-low select. Each word holds a 4-bit command followed by a 12-bit code, most significant bit first. The three pins are brought into the system clock through synchronizers. A bit is taken on every falling serial-clock edge that is seen while select is low.

When the sixteenth bit arrives, the word is copied into an input register at once, without waiting for select to rise. The command is then decoded. The load command copies the 12-bit code into the DAC register, which drives the converter's code. Any other command does nothing except raise a one-cycle flag. After a word has been committed, the interface ignores the serial clock until select goes high and then low again.

Top module: `sdac_front`

## Requirements
- R1: A word is 16 bits, sent MSB first: bits 15..12 are the command and bits 11..0 are the code. Command 4'b0000 loads the code into `dac_code_o`.
- R2: A bit is taken from `sdi_i` at the falling edge of `sck_i`. Changes on `sdi_i` while `sck_i` is low before the next rise have no effect on that bit.
- R3: While `csn_i` is high, edges on `sck_i` have no effect. They do not load bits and do not advance the bit count.
- R4: The word commits on the 16th falling edge while `csn_i` is still low. `dac_code_o` takes the new code within 4 system clocks of that edge at the pins.
- R5: After a commit, further `sck_i` edges in the same low period of `csn_i` are ignored until `csn_i` has gone high.
- R6: If `csn_i` rises after fewer than 16 bits, the partial word is discarded. The next word is decoded from its own first bit.
- R7: A command other than 4'b0000 leaves `dac_code_o` unchanged and pulses `nop_cmd_o` high for one cycle.
- R8: Every load command pulses `dac_update_o` high for exactly one cycle, even when the loaded code equals the current one. `dac_update_o` and `nop_cmd_o` are never high together.
- R9: A synchronous active-high `rst` sets `dac_code_o` to 0, holds both strobes low and discards any partial word.
- R10: If `csn_i` rises in the same system clock as the 16th falling edge, release wins and the word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| csn_i | input | 1 | Active-low select, asynchronous |
| dac_code_o | output | 12 | DAC register contents |
| dac_update_o | output | 1 | One-cycle strobe when the DAC register is loaded |
| nop_cmd_o | output | 1 | One-cycle strobe when a non-load command is committed |

## Verification
Two events can land in one system clock: the release of select and the 16th falling serial-clock edge. Both pins pass through synchronizers of equal depth, so the bench drives the two transitions at the same system-clock edge to make them coincide. It then checks that the code is unchanged and that no update strobe appears. A second overlap is extra serial-clock edges arriving after a commit while select is still low. Here the bench checks that the committed code survives and that exactly one update strobe was seen.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int CMD_BITS_DEF  = 4;
    localparam int CODE_BITS_DEF = 12;
    localparam int SYNC_DEPTH_DEF = 2;

    // order of the synchronized pin bundle
    localparam int PIN_SCK = 0;
    localparam int PIN_SDI = 1;
    localparam int PIN_CSN = 2;
    localparam int PIN_CNT = 3;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : gen_stage
            if (g == 0) begin : gen_first
                always_comb stg_d[g] = din;
            end else begin : gen_next
                always_comb stg_d[g] = stg_q[g-1];
            end
            always_ff @(posedge clk) begin
                if (rst) stg_q[g] <= RST_VAL;
                else     stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_s,
    input  logic                 sdi_s,
    input  logic                 csn_s,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 word_vld_o
);
    localparam int               CNT_W = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_BITS - 1);

    typedef struct packed {
        logic [WORD_BITS-1:0] shift;
        logic [CNT_W-1:0]     cnt;
        logic                 lock;
        logic                 sck_prev;
        logic [WORD_BITS-1:0] latch;
        logic                 latch_vld;
    } shf_st_t;

    shf_st_t st_d, st_q;
    logic    fall;

    always_comb begin
        st_d           = st_q;
        st_d.latch_vld = 1'b0;
        st_d.sck_prev  = sck_s;
        fall           = st_q.sck_prev & ~sck_s;
        if (csn_s) begin
            // select released: drop any partial word, rearm
            st_d.shift = '0;
            st_d.cnt   = '0;
            st_d.lock  = 1'b0;
        end else if (fall && !st_q.lock) begin
            st_d.shift = {st_q.shift[WORD_BITS-2:0], sdi_s};
            if (st_q.cnt == LAST) begin
                st_d.latch     = {st_q.shift[WORD_BITS-2:0], sdi_s};
                st_d.latch_vld = 1'b1;
                st_d.lock      = 1'b1;
                st_d.cnt       = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_o     = st_q.latch;
    assign word_vld_o = st_q.latch_vld;

    AST_CS_HIGH_REARMS: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> (st_q.cnt == '0 && !st_q.lock)) else $error("rearm"); // R3
    AST_COMMIT_SETS_LOCK: assert property (@(posedge clk) disable iff (rst)
        st_q.latch_vld |-> st_q.lock) else $error("lock"); // R4
    AST_COMMIT_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
        st_q.latch_vld |-> $past(st_q.cnt) == LAST) else $error("count"); // R4
    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        st_q.lock |=> !st_q.latch_vld) else $error("lockout"); // R5
    AST_RELEASE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> !st_q.latch_vld) else $error("release"); // R10
endmodule

// File: rtl/sdac_cmd.sv
module sdac_cmd #(
    parameter int              CMD_BITS  = 4,
    parameter int              CODE_BITS = 12,
    parameter logic [CMD_BITS-1:0] LOAD_CMD = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CMD_BITS+CODE_BITS-1:0] word_i,
    input  logic                          word_vld_i,
    output logic [CODE_BITS-1:0]          code_o,
    output logic                          upd_o,
    output logic                          nop_o
);
    typedef struct packed {
        logic [CODE_BITS-1:0] code;
        logic                 upd;
        logic                 nop;
    } cmd_st_t;

    cmd_st_t              st_d, st_q;
    logic [CMD_BITS-1:0]  cmd_f;
    logic [CODE_BITS-1:0] data_f;

    always_comb begin
        cmd_f    = word_i[CMD_BITS+CODE_BITS-1:CODE_BITS];
        data_f   = word_i[CODE_BITS-1:0];
        st_d     = st_q;
        st_d.upd = 1'b0;
        st_d.nop = 1'b0;
        if (word_vld_i) begin
            if (cmd_f == LOAD_CMD) begin
                st_d.code = data_f;
                st_d.upd  = 1'b1;
            end else begin
                st_d.nop = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign upd_o  = st_q.upd;
    assign nop_o  = st_q.nop;

    AST_NOP_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
        st_q.nop |-> st_q.code == $past(st_q.code)) else $error("nop"); // R7
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(st_q.upd && st_q.nop)) else $error("excl"); // R8
    AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        st_q.upd |=> !st_q.upd) else $error("pulse"); // R8
    AST_CODE_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (rst)
        !st_q.upd |-> $stable(st_q.code)) else $error("stable"); // R8
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
    parameter int CMD_BITS   = sdac_pkg::CMD_BITS_DEF,
    parameter int CODE_BITS  = sdac_pkg::CODE_BITS_DEF,
    parameter int SYNC_DEPTH = sdac_pkg::SYNC_DEPTH_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_i,
    input  logic                 sdi_i,
    input  logic                 csn_i,
    output logic [CODE_BITS-1:0] dac_code_o,
    output logic                 dac_update_o,
    output logic                 nop_cmd_o
);
    import sdac_pkg::*;

    localparam int                 WORD_BITS = CMD_BITS + CODE_BITS;
    localparam logic [PIN_CNT-1:0] PIN_RST   = PIN_CNT'(1) << PIN_CSN;

    logic [PIN_CNT-1:0]   pins_raw, pins_s;
    logic [WORD_BITS-1:0] word;
    logic                 word_vld;

    always_comb begin
        pins_raw          = '0;
        pins_raw[PIN_SCK] = sck_i;
        pins_raw[PIN_SDI] = sdi_i;
        pins_raw[PIN_CSN] = csn_i;
    end

    sdac_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_DEPTH), .RST_VAL(PIN_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pins_raw),
        .dout(pins_s)
    );

    sdac_shifter #(.WORD_BITS(WORD_BITS)) u_shf (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (pins_s[PIN_SCK]),
        .sdi_s     (pins_s[PIN_SDI]),
        .csn_s     (pins_s[PIN_CSN]),
        .word_o    (word),
        .word_vld_o(word_vld)
    );

    sdac_cmd #(.CMD_BITS(CMD_BITS), .CODE_BITS(CODE_BITS)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .word_i    (word),
        .word_vld_i(word_vld),
        .code_o    (dac_code_o),
        .upd_o     (dac_update_o),
        .nop_o     (nop_cmd_o)
    );
endmodule

// File: tb/sdac_front_tb.sv
module sdac_front_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        csn = 1'b1;
    logic [11:0] code;
    logic        upd, nop;

    int checks = 0;
    int fails  = 0;
    int upd_tot = 0;
    int nop_tot = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdac_front dut_i (
        .clk(clk), .rst(rst), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
        .dac_code_o(code), .dac_update_o(upd), .nop_cmd_o(nop)
    );

    always @(negedge clk) begin
        if (!rst && upd) upd_tot++;
        if (!rst && nop) nop_tot++;
    end

    // {cmd[4], data[12], exp_code[12], exp_upd[2], exp_nop[2]}
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {4'h0, 12'hA5C, 12'hA5C, 2'd1, 2'd0},   // R1
        {4'h0, 12'hFFF, 12'hFFF, 2'd1, 2'd0},   // R1
        {4'h3, 12'h123, 12'hFFF, 2'd0, 2'd1},   // R7
        {4'h0, 12'h000, 12'h000, 2'd1, 2'd0},   // R1
        {4'h8, 12'h555, 12'h000, 2'd0, 2'd1},   // R7
        {4'h0, 12'h000, 12'h000, 2'd1, 2'd0},   // R8 same value
        {4'h0, 12'h801, 12'h801, 2'd1, 2'd0}    // R1 MSB first
    };

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit; SDI is flipped during the low phase after the fall (R2)
    task automatic bit_out(input logic b);
        sdi = b;   wclk(2);
        sck = 1'b1; wclk(4);
        sck = 1'b0; wclk(2);
        sdi = ~b;  wclk(2);
    endtask

    task automatic bits_out(input logic [15:0] w, input int n);
        for (int i = 15; i > 15 - n; i--) bit_out(w[i]);
    endtask

    task automatic xfer(input logic [15:0] w);
        csn = 1'b0; wclk(4);
        bits_out(w, 16);
        wclk(4);
        csn = 1'b1; wclk(8);
    endtask

    initial begin
        int u0, n0;
        wclk(4);
        check(code == 12'h0 && !upd && !nop, "R9 reset", code, 0);
        rst = 1'b0; wclk(4);
        check(code == 12'h0, "R9 after release", code, 0);

        for (int i = 0; i < NV; i++) begin
            u0 = upd_tot; n0 = nop_tot;
            xfer(VEC[i][31:16]);
            check(code == VEC[i][15:4], "R1/R7 vector code", code, VEC[i][15:4]);
            check(upd_tot - u0 == int'(VEC[i][3:2]), "R8 update pulses", upd_tot - u0, VEC[i][3:2]);
            check(nop_tot - n0 == int'(VEC[i][1:0]), "R7 nop pulses", nop_tot - n0, VEC[i][1:0]);
        end

        // R2: every bit carries an inverted glitch while SCK is low
        xfer({4'h0, 12'h6B9});
        check(code == 12'h6B9, "R2 falling-edge sample", code, 12'h6B9);

        // R4 commit with select still low, then R5 lockout
        u0 = upd_tot;
        csn = 1'b0; wclk(4);
        bits_out({4'h0, 12'h3C3}, 16);
        wclk(4);
        check(code == 12'h3C3, "R4 commit before release", code, 12'h3C3);
        bits_out({4'h0, 12'h111}, 16);
        wclk(6);
        check(code == 12'h3C3, "R5 extra clocks ignored", code, 12'h3C3);
        check(upd_tot - u0 == 1, "R5 single update", upd_tot - u0, 1);
        csn = 1'b1; wclk(8);

        // R3 clocks with select high
        u0 = upd_tot;
        bits_out({4'h0, 12'h777}, 16);
        wclk(6);
        check(code == 12'h3C3 && upd_tot == u0, "R3 idle clocks ignored", code, 12'h3C3);
        xfer({4'h0, 12'h246});
        check(code == 12'h246, "R3 count not advanced", code, 12'h246);

        // R6 partial word dropped
        u0 = upd_tot;
        csn = 1'b0; wclk(4);
        bits_out({4'h0, 12'h0F0}, 10);
        csn = 1'b1; wclk(8);
        check(code == 12'h246 && upd_tot == u0, "R6 partial discarded", code, 12'h246);
        xfer({4'h0, 12'h9AB});
        check(code == 12'h9AB, "R6 next word fresh", code, 12'h9AB);

        // R10 release together with 16th fall
        u0 = upd_tot;
        csn = 1'b0; wclk(4);
        bits_out({4'h0, 12'hC0D}, 15);
        sdi = 1'b1; wclk(2);
        sck = 1'b1; wclk(4);
        sck = 1'b0; csn = 1'b1; wclk(10);
        check(code == 12'h9AB && upd_tot == u0, "R10 release wins", code, 12'h9AB);
        xfer({4'h0, 12'h0C0});
        check(code == 12'h0C0, "R10 recovery", code, 12'h0C0);

        // R9 reset in mid-word
        csn = 1'b0; wclk(4);
        bits_out({4'h0, 12'hEEE}, 8);
        rst = 1'b1; wclk(3);
        check(code == 12'h0 && !upd && !nop, "R9 mid-word reset", code, 0);
        rst = 1'b0;
        csn = 1'b1; wclk(8);
        xfer({4'h0, 12'h5A5});
        check(code == 12'h5A5, "R9 clean word after reset", code, 12'h5A5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule